// File: doc/BRIEF.md
# Ring-Array Full-Search Phase Sequencer

This controller drives a ring-connected block-matching array through one complete full search. A single start pulse launches the run. The search window is cut into vertical strips. The sequencer first fills the array and its side registers. Inside each strip it then alternates a compute cycle with a refill cycle. Between strips it spends a fixed number of cycles on vertical reloads. It also decides, cycle by cycle, who owns the search-window read port. The array has priority, and a half-pel requester gets the port in every cycle the array leaves free.

Parameters: `N` is the block side, `DX`/`DY` are the search half-ranges and `SRX` is the number of side-register columns. The strip count is `S = (2*DX+N)/(N+SRX)` and must divide evenly. Each strip occupies `2*DY+N` consecutive search-window words, so word `k*(2*DY+N)+row` holds row `row` of strip `k`. Strips are numbered from 0.

Top module: `ring_search_sequencer`

## Requirements
- R1: Out of reset, and while no run is active, `busy`, `init_load`, `cand_valid`, `shift_down`, `sw_rd`, `tb_rd` and `done` are all 0. With no start, the block stays in that state.
- R2: A start seen at a clock edge while idle begins a fill of exactly N cycles, starting the next cycle. In fill cycle i, `init_load`, `tb_rd` and `sw_rd` are 1, `tb_addr` = i and `sw_addr` = i.
- R3: After the fill, each strip runs 2*DY compute cycles. Each compute cycle lasts one cycle, raises `cand_valid` exactly once and leaves `sw_rd` at 0. `cand_strip` gives the strip k and `cand_step` gives the compute index 0..2*DY-1.
- R4: A refill cycle follows every compute cycle except the last one of a strip. The refill after compute j of strip k reads `sw_addr` = k*(2*DY+N)+N+j.
- R5: Between strip k and strip k+1 there are exactly N vertical-reload cycles with `shift_down` = 1. Reload cycle i reads `sw_addr` = (k+1)*(2*DY+N)+i.
- R6: The horizontal shift direction follows a serpentine. `shift_left` is 1 in the compute cycles of odd strips and 0 elsewhere, so even strips shift right.
- R7: `sw_swap` is 1 exactly when the search window is read for an odd strip. It exchanges the upper and lower halves of the word through addressing.
- R8: `hp_grant` = `hp_req` AND NOT `sw_rd` in every cycle, idle time included. The array always wins a same-cycle conflict.
- R9: `done` is high for one cycle, the cycle after the last compute of the last strip. `busy` is high from the first fill cycle through that cycle. The block is idle in the following cycle.
- R10: A start pulse while a run is active is ignored, and the schedule continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch pulse, honoured only when idle |
| hp_req | input | 1 | Half-pel unit requests the window read port |
| busy | output | 1 | A run is in progress |
| init_load | output | 1 | Fill cycle: array and side registers load |
| cand_valid | output | 1 | Compute cycle: capture one SAD candidate |
| cand_strip | output | max(1,clog2(S)) | Strip of the current candidate |
| cand_step | output | clog2(2*DY) | Compute index inside the strip |
| shift_left | output | 1 | Horizontal shift to the left in this compute cycle |
| shift_down | output | 1 | Vertical reload cycle |
| sw_rd | output | 1 | Array reads the search window |
| sw_addr | output | clog2(S*(2*DY+N)) | Search-window word address |
| sw_swap | output | 1 | Exchange word halves for this read |
| tb_rd | output | 1 | Template memory read |
| tb_addr | output | clog2(N) | Template row address |
| hp_grant | output | 1 | Window port handed to the half-pel unit |
| done | output | 1 | Search complete |

## Verification
Two functions can fall in the same cycle: a half-pel request and an array read of the window. The bench holds `hp_req` high through whole runs, and also drives it in an irregular pattern, so requests land on fill, refill, reload and compute cycles alike. It judges each cycle against a schedule it derives from the cycle offset alone. A grant is expected only when that schedule has no window read. A second collision comes from a start pulse injected mid-run, which must leave every later output unchanged.

// File: rtl/rss_pkg.sv
package rss_pkg;

  typedef enum logic [2:0] {
    PH_WAIT  = 3'd0,
    PH_INIT  = 3'd1,
    PH_CALC  = 3'd2,
    PH_INPUT = 3'd3,
    PH_IDLE  = 3'd4,
    PH_FIN   = 3'd5
  } phase_e;

  function automatic int strip_count(input int n, input int dx, input int srx);
    return (2 * dx + n) / (n + srx);
  endfunction

  function automatic int rows_per_strip(input int n, input int dy);
    return 2 * dy + n;
  endfunction

  function automatic int sw_word(input int strip, input int row, input int rows);
    return strip * rows + row;
  endfunction

  function automatic int bits_for(input int count);
    return (count > 1) ? $clog2(count) : 1;
  endfunction

endpackage

// File: rtl/rss_phase_fsm.sv
module rss_phase_fsm
  import rss_pkg::*;
#(
  parameter int N       = 16,
  parameter int DY      = 8,
  parameter int STRIPS  = 2,
  parameter int CNT_W   = 4,
  parameter int STEP_W  = 4,
  parameter int STRIP_W = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  output phase_e             phase,
  output logic [CNT_W-1:0]   cnt,
  output logic [STEP_W-1:0]  step,
  output logic [STRIP_W-1:0] strip,
  output logic               start_accept,
  output logic               last_calc
);

  localparam int STEP_LAST = 2 * DY - 1;

  logic cnt_last, step_last, strip_last;

  assign cnt_last     = (cnt == CNT_W'(N - 1));
  assign step_last    = (step == STEP_W'(STEP_LAST));
  assign strip_last   = (strip == STRIP_W'(STRIPS - 1));
  assign start_accept = start && (phase == PH_WAIT);
  assign last_calc    = (phase == PH_CALC) && step_last && strip_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_WAIT;
      cnt   <= '0;
      step  <= '0;
      strip <= '0;
    end else begin
      case (phase)
        PH_WAIT: begin
          if (start_accept) begin
            phase <= PH_INIT;
            cnt   <= '0;
            step  <= '0;
            strip <= '0;
          end
        end
        PH_INIT: begin
          if (cnt_last) begin
            phase <= PH_CALC;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_CALC: begin
          if (!step_last) begin
            phase <= PH_INPUT;
          end else if (strip_last) begin
            phase <= PH_FIN;
          end else begin
            phase <= PH_IDLE;
            cnt   <= '0;
            step  <= '0;
            strip <= strip + 1'b1;
          end
        end
        PH_INPUT: begin
          phase <= PH_CALC;
          step  <= step + 1'b1;
        end
        PH_IDLE: begin
          if (cnt_last) begin
            phase <= PH_CALC;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_FIN:  phase <= PH_WAIT;
        default: phase <= PH_WAIT;
      endcase
    end
  end

  // R1
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_WAIT && !start) |=> (phase == PH_WAIT));

  // R2
  init_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_INIT && cnt_last) |=> (phase == PH_CALC && step == '0));

  // R3
  calc_alternate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_CALC && !step_last) |=> (phase == PH_INPUT));

  // R10
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_WAIT && phase != PH_INIT) |=> (phase != PH_INIT));

endmodule

// File: rtl/rss_addr_gen.sv
module rss_addr_gen
  import rss_pkg::*;
#(
  parameter int N       = 16,
  parameter int DY      = 8,
  parameter int CNT_W   = 4,
  parameter int STEP_W  = 4,
  parameter int STRIP_W = 1,
  parameter int SWA_W   = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  phase_e             phase,
  input  logic [CNT_W-1:0]   cnt,
  input  logic [STEP_W-1:0]  step,
  input  logic [STRIP_W-1:0] strip,
  output logic               init_load,
  output logic               cand_valid,
  output logic               shift_left,
  output logic               shift_down,
  output logic               sw_rd,
  output logic [SWA_W-1:0]   sw_addr,
  output logic               sw_swap,
  output logic               tb_rd,
  output logic [CNT_W-1:0]   tb_addr
);

  localparam int ROWS = rows_per_strip(N, DY);

  logic odd_strip;
  int   row;

  assign odd_strip  = strip[0];
  assign init_load  = (phase == PH_INIT);
  assign cand_valid = (phase == PH_CALC);
  assign shift_down = (phase == PH_IDLE);
  assign shift_left = cand_valid && odd_strip;
  assign tb_rd      = init_load;
  assign tb_addr    = cnt;
  assign sw_rd      = (phase == PH_INIT) || (phase == PH_INPUT) || (phase == PH_IDLE);
  assign sw_swap    = sw_rd && odd_strip;

  always_comb begin
    case (phase)
      PH_INPUT: row = N + int'(step);
      default:  row = int'(cnt);
    endcase
    sw_addr = sw_rd ? SWA_W'(sw_word(int'(strip), row, ROWS)) : '0;
  end

  // R3
  calc_port_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cand_valid |-> !sw_rd);

  // R6
  dir_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cand_valid && $past(phase) == PH_INPUT && $past(cand_valid, 2))
      |-> (shift_left == $past(shift_left, 2)));

  // R4
  refill_stride_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_INPUT && $past(phase, 2) == PH_INPUT)
      |-> (sw_addr == $past(sw_addr, 2) + SWA_W'(1)));

endmodule

// File: rtl/rss_port_arb.sv
module rss_port_arb (
  input  logic clk,
  input  logic rst_n,
  input  logic array_rd,
  input  logic hp_req,
  output logic hp_grant
);

  assign hp_grant = hp_req && !array_rd;

  // R8
  grant_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hp_grant |-> (hp_req && !array_rd));

endmodule

// File: rtl/ring_search_sequencer.sv
module ring_search_sequencer
  import rss_pkg::*;
#(
  parameter int N   = 16,
  parameter int DX  = 16,
  parameter int DY  = 8,
  parameter int SRX = 8,
  localparam int STRIPS  = strip_count(N, DX, SRX),
  localparam int ROWS    = rows_per_strip(N, DY),
  localparam int CNT_W   = bits_for(N),
  localparam int STEP_W  = bits_for(2 * DY),
  localparam int STRIP_W = bits_for(STRIPS),
  localparam int SWA_W   = bits_for(STRIPS * ROWS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               hp_req,
  output logic               busy,
  output logic               init_load,
  output logic               cand_valid,
  output logic [STRIP_W-1:0] cand_strip,
  output logic [STEP_W-1:0]  cand_step,
  output logic               shift_left,
  output logic               shift_down,
  output logic               sw_rd,
  output logic [SWA_W-1:0]   sw_addr,
  output logic               sw_swap,
  output logic               tb_rd,
  output logic [CNT_W-1:0]   tb_addr,
  output logic               hp_grant,
  output logic               done
);

  phase_e             phase;
  logic [CNT_W-1:0]   cnt;
  logic [STEP_W-1:0]  step;
  logic [STRIP_W-1:0] strip;
  logic               start_accept;
  logic               last_calc;

  rss_phase_fsm #(
    .N(N), .DY(DY), .STRIPS(STRIPS),
    .CNT_W(CNT_W), .STEP_W(STEP_W), .STRIP_W(STRIP_W)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start),
    .phase(phase), .cnt(cnt), .step(step), .strip(strip),
    .start_accept(start_accept), .last_calc(last_calc)
  );

  rss_addr_gen #(
    .N(N), .DY(DY), .CNT_W(CNT_W), .STEP_W(STEP_W),
    .STRIP_W(STRIP_W), .SWA_W(SWA_W)
  ) u_addr (
    .clk(clk), .rst_n(rst_n), .phase(phase), .cnt(cnt), .step(step), .strip(strip),
    .init_load(init_load), .cand_valid(cand_valid), .shift_left(shift_left),
    .shift_down(shift_down), .sw_rd(sw_rd), .sw_addr(sw_addr), .sw_swap(sw_swap),
    .tb_rd(tb_rd), .tb_addr(tb_addr)
  );

  rss_port_arb u_arb (
    .clk(clk), .rst_n(rst_n), .array_rd(sw_rd), .hp_req(hp_req), .hp_grant(hp_grant)
  );

  assign busy       = (phase != PH_WAIT);
  assign done       = (phase == PH_FIN);
  assign cand_strip = cand_valid ? strip : '0;
  assign cand_step  = cand_valid ? step : '0;

  // R9
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_calc |=> (done && busy));

  // R9
  done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!busy && !done));

  // R2
  start_to_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_accept |=> (init_load && tb_addr == '0));

endmodule

// File: tb/ring_search_sequencer_tb.sv
module ring_search_sequencer_tb;

  localparam int N   = 4;
  localparam int DX  = 4;
  localparam int DY  = 2;
  localparam int SRX = 2;
  localparam int S     = (2 * DX + N) / (N + SRX);
  localparam int HR    = 2 * DY + N;
  localparam int PAIR  = 4 * DY - 1;
  localparam int L     = PAIR + N;
  localparam int TOTAL = N + S * PAIR + (S - 1) * N + 1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       hp_req = 1'b0;
  logic       busy, init_load, cand_valid, shift_left, shift_down;
  logic       sw_rd, sw_swap, tb_rd, hp_grant, done;
  logic [0:0] cand_strip;
  logic [1:0] cand_step;
  logic [3:0] sw_addr;
  logic [1:0] tb_addr;

  int checks = 0;
  int errors = 0;

  int e_busy, e_init, e_cand, e_strip, e_step, e_left, e_down;
  int e_swrd, e_swaddr, e_swap, e_tbrd, e_tbaddr, e_done;

  always #5 clk = ~clk;

  ring_search_sequencer #(.N(N), .DX(DX), .DY(DY), .SRX(SRX)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .hp_req(hp_req),
    .busy(busy), .init_load(init_load), .cand_valid(cand_valid),
    .cand_strip(cand_strip), .cand_step(cand_step), .shift_left(shift_left),
    .shift_down(shift_down), .sw_rd(sw_rd), .sw_addr(sw_addr), .sw_swap(sw_swap),
    .tb_rd(tb_rd), .tb_addr(tb_addr), .hp_grant(hp_grant), .done(done)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic clear_exp();
    e_busy = 0; e_init = 0; e_cand = 0; e_strip = 0; e_step = 0; e_left = 0;
    e_down = 0; e_swrd = 0; e_swaddr = 0; e_swap = 0; e_tbrd = 0; e_tbaddr = 0; e_done = 0;
  endtask

  // Expected outputs at offset t from the first fill cycle, by arithmetic on t.
  task automatic expect_at(input int t);
    int u, k, r;
    clear_exp();
    e_busy = 1;
    if (t < N) begin
      e_init = 1; e_tbrd = 1; e_tbaddr = t; e_swrd = 1; e_swaddr = t;
    end else begin
      u = t - N;
      k = u / L;
      r = u % L;
      if (k == S - 1 && r == PAIR) begin
        e_done = 1;
      end else if (r < PAIR) begin
        if (r % 2 == 0) begin
          e_cand = 1; e_strip = k; e_step = r / 2; e_left = k % 2;
        end else begin
          e_swrd = 1; e_swaddr = k * HR + N + (r - 1) / 2; e_swap = k % 2;
        end
      end else begin
        e_down = 1; e_swrd = 1;
        e_swaddr = (k + 1) * HR + (r - PAIR);
        e_swap = (k + 1) % 2;
      end
    end
  endtask

  task automatic compare_all(input int hreq);
    chk("R1/R9", "busy", int'(busy), e_busy);
    chk("R2", "init_load", int'(init_load), e_init);
    chk("R2", "tb_rd", int'(tb_rd), e_tbrd);
    if (e_tbrd != 0) chk("R2", "tb_addr", int'(tb_addr), e_tbaddr);
    chk("R3", "cand_valid", int'(cand_valid), e_cand);
    if (e_cand != 0) begin
      chk("R3", "cand_strip", int'(cand_strip), e_strip);
      chk("R3", "cand_step", int'(cand_step), e_step);
    end
    chk("R4", "sw_rd", int'(sw_rd), e_swrd);
    if (e_swrd != 0) chk("R4", "sw_addr", int'(sw_addr), e_swaddr);
    chk("R5", "shift_down", int'(shift_down), e_down);
    chk("R6", "shift_left", int'(shift_left), e_left);
    chk("R7", "sw_swap", int'(sw_swap), e_swap);
    chk("R8", "hp_grant", int'(hp_grant), (hreq != 0 && e_swrd == 0) ? 1 : 0);
    chk("R9", "done", int'(done), e_done);
  endtask

  // One full run; hp_mode 0 = irregular requests, 1 = constant request.
  task automatic run_search(input int hp_mode, input int poke_at);
    int hreq;
    @(negedge clk);
    start = 1'b1;
    hp_req = 1'b0;
    @(negedge clk);
    start = 1'b0;
    for (int t = 0; t < TOTAL; t++) begin
      hreq = (hp_mode == 1) ? 1 : (((t * 7 + 3) % 5) < 3 ? 1 : 0);
      hp_req = hreq[0];
      start = (t == poke_at || t == poke_at + 9);  // R10 mid-run starts
      #1;
      expect_at(t);
      compare_all(hreq);
      @(negedge clk);
    end
    start = 1'b0;
    hp_req = 1'b1;
    #1;
    clear_exp();
    compare_all(1);  // R9 idle again after done
  endtask

  initial begin : watchdog
    for (int c = 0; c < 100000; c++) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stimulus
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: idle after reset and with no start
    for (int i = 0; i < 4; i++) begin
      hp_req = i[0];
      #1;
      clear_exp();
      compare_all(i % 2);
      @(negedge clk);
    end
    run_search(0, -100);
    run_search(1, 6);
    run_search(0, 1);
    // R1: stays idle without start
    hp_req = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      #1;
      clear_exp();
      compare_all(0);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule